// File: doc/BRIEF.md
# Protected Clock-Source Start Controller

This block sequences the start of three clock sources and reports to software when each has had time to settle. Software programs each source's settings, enables the source, and then waits. The controller counts out a stabilization delay for that source and raises a sticky start flag when the delay expires. Software may use a source's clock once its flag reads 1. Each flag can drive a single interrupt line through its own enable bit.

The settings registers are guarded by a 16-bit key. They accept writes only while the key register holds the unlock value. Storing any other value re-arms the guard. The enable, interrupt-enable and flag registers are never guarded, so software can restore protection before it starts a source.

Each source has its own three-state timer. **T_IDLE** waits for the enable bit. **T_IDLE→T_WAIT** happens when the enable is seen high, and loads the delay. **T_WAIT→T_WAIT** counts down. **T_WAIT→T_STABLE** happens when the count is at zero, and emits the one-cycle done pulse that sets the flag. **T_WAIT→T_IDLE** and **T_STABLE→T_IDLE** happen whenever the enable is seen low. The key guard has two states. It enters **K_OPEN** when the key write equals 0x0096. It enters **K_LOCKED** on any other key write, and it is also in K_LOCKED after reset.

Top module: `osc_start_ctrl`

Register map (word addresses; `wdata`/`rdata` are 16 bits):

| Addr | Name | Bits |
|------|------|------|
| 0 | KEY | write: 16-bit key; read: bit0 = 1 while open |
| 1 | ENABLE | [2:0] enable for source 2..0 |
| 2 | FLAG | [2:0] start flags, write 1 to clear |
| 3 | IRQEN | [2:0] interrupt enables |
| 4 | CFG0 | [2:0] frequency select (guarded) |
| 5 | CFG1 | [1:0] gain, [3:2] boost gain, [6:4] capacitor, [7] boost on, [9:8] wait select (guarded) |
| 6 | CFG2 | [1:0] gain, [4:2] wait select (guarded) |
| 7 | STATUS | [2:0] source currently stable (read only) |

## Requirements
- R1: After reset, all registers read 0, the guard is locked (KEY reads 0), STATUS is 0 and `irq` is 0.
- R2: Writing 16'h0096 to KEY opens the guard, and KEY then reads 1.
- R3: Writing any other value to KEY closes the guard, and KEY then reads 0.
- R4: Writes to CFG0, CFG1 or CFG2 while the guard is locked are ignored, and the fields keep their old values.
- R5: ENABLE, IRQEN and FLAG accept writes whether the guard is open or locked.
- R6: A source's flag is 0 for the first N clock edges after the edge that writes its enable bit from 0 to 1, and it is 1 after edge N+1. N = 2^(BASE_EXP + 2·sel). Source 0 always uses sel = 0. Source 1 uses CFG1[9:8], and source 2 uses CFG2[4:2].
- R7: Writing 1 to a FLAG bit clears it. Writing 0 leaves it unchanged.
- R8: Clearing an enable bit drops that source's STATUS bit one edge later but leaves its flag set. Re-enabling restarts the full delay.
- R9: `irq` is high exactly when some source has both its flag and its interrupt enable set.
- R10: While the guard is open, the CFG registers store and read back the field layout given in the map.
- R11: A STATUS bit is 1 only while its source is enabled and its delay has expired, and it is 0 during the wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. Guarded fields stay unchanged whenever the guard was locked. A flag only rises at the moment its source becomes stable. A flag never falls without a clear write. STATUS follows a low enable within one edge. `irq` stays low when no flag or no interrupt enable is set. The bench scenarios cover the behaviours that need a known stimulus. These are the exact delay length for each wait select, that the unlock value opens the guard and other values close it, and the readback of field positions. They also cover the restart of the delay after re-enabling.

// File: rtl/osc_start_pkg.sv
package osc_start_pkg;
    localparam int NSRC = 3;
    localparam int SEL_W = 3;
    localparam logic [15:0] UNLOCK_KEY = 16'h0096;

    typedef enum logic [2:0] {
        A_KEY  = 3'd0,
        A_EN   = 3'd1,
        A_FLAG = 3'd2,
        A_IE   = 3'd3,
        A_CFG0 = 3'd4,
        A_CFG1 = 3'd5,
        A_CFG2 = 3'd6,
        A_STAT = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        T_IDLE   = 2'd0,
        T_WAIT   = 2'd1,
        T_STABLE = 2'd2
    } tmr_state_e;

    typedef enum logic {
        K_LOCKED = 1'b0,
        K_OPEN   = 1'b1
    } key_state_e;

    typedef struct packed {
        logic [1:0] wsel;
        logic       boost_en;
        logic [2:0] cap;
        logic [1:0] boost_gain;
        logic [1:0] gain;
    } cfg1_t;

    typedef struct packed {
        logic [2:0] wsel;
        logic [1:0] gain;
    } cfg2_t;
endpackage

// File: rtl/osc_key_guard.sv
module osc_key_guard #(
    parameter int KEY_W = 16,
    parameter logic [KEY_W-1:0] UNLOCK = KEY_W'(16'h0096)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_wdata,
    output logic             unlocked
);
    import osc_start_pkg::*;

    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (key_we) begin
            state_d = (key_wdata == UNLOCK) ? K_OPEN : K_LOCKED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= K_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            K_OPEN:   unlocked = 1'b1;
            K_LOCKED: unlocked = 1'b0;
            default:  unlocked = 1'b0;
        endcase
    end
endmodule

// File: rtl/osc_src_timer.sv
module osc_src_timer #(
    parameter int SEL_W    = 3,
    parameter int BASE_EXP = 4,
    parameter int STEP_EXP = 2,
    parameter int CNT_W    = BASE_EXP + STEP_EXP * ((1 << SEL_W) - 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] wsel,
    output logic             done,
    output logic             stable
);
    import osc_start_pkg::*;

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_val;
    int unsigned      shamt;

    always_comb begin
        shamt    = BASE_EXP + STEP_EXP * int'(wsel);
        load_val = (CNT_W'(1) << shamt) - CNT_W'(1);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            T_IDLE: begin
                if (en) begin
                    state_d = T_WAIT;
                    cnt_d   = load_val;
                end
            end
            T_WAIT: begin
                if (!en) begin
                    state_d = T_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == '0) begin
                    state_d = T_STABLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            T_STABLE: begin
                if (!en) state_d = T_IDLE;
            end
            default: state_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        done   = 1'b0;
        stable = 1'b0;
        unique case (state_q)
            T_IDLE:   ;
            T_WAIT:   done = en && (cnt_q == '0);
            T_STABLE: stable = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/osc_start_ctrl.sv
module osc_start_ctrl #(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 16,
    parameter int BASE_EXP   = 4,
    parameter int STEP_EXP   = 2,
    parameter int SRC0_WSEL  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    import osc_start_pkg::*;

    localparam int CNT_W = BASE_EXP + STEP_EXP * ((1 << SEL_W) - 1) + 1;

    logic [NSRC-1:0] en_q, ie_q, flag_q, done_v, stable_v;
    logic [2:0]      cfg0_q;
    cfg1_t           cfg1_q;
    cfg2_t           cfg2_q;
    logic            unlocked;
    logic [NSRC-1:0] clr_mask;
    logic [SEL_W-1:0] wsel_v [NSRC];

    function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_addr_e r);
        return a == ADDR_W'(r);
    endfunction

    osc_key_guard #(
        .KEY_W  (16),
        .UNLOCK (UNLOCK_KEY)
    ) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_we    (wr && hit(addr, A_KEY)),
        .key_wdata (wdata[15:0]),
        .unlocked  (unlocked)
    );

    always_comb begin
        wsel_v[0] = SEL_W'(SRC0_WSEL);
        wsel_v[1] = SEL_W'(cfg1_q.wsel);
        wsel_v[2] = cfg2_q.wsel;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        osc_src_timer #(
            .SEL_W    (SEL_W),
            .BASE_EXP (BASE_EXP),
            .STEP_EXP (STEP_EXP),
            .CNT_W    (CNT_W)
        ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_q[i]),
            .wsel   (wsel_v[i]),
            .done   (done_v[i]),
            .stable (stable_v[i])
        );
    end

    assign clr_mask = (wr && hit(addr, A_FLAG)) ? wdata[NSRC-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            ie_q   <= '0;
            flag_q <= '0;
            cfg0_q <= '0;
            cfg1_q <= '0;
            cfg2_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_mask) | done_v;
            if (wr) begin
                if (hit(addr, A_EN)) en_q <= wdata[NSRC-1:0];
                if (hit(addr, A_IE)) ie_q <= wdata[NSRC-1:0];
                if (unlocked) begin
                    if (hit(addr, A_CFG0)) cfg0_q <= wdata[2:0];
                    if (hit(addr, A_CFG1)) cfg1_q <= wdata[$bits(cfg1_t)-1:0];
                    if (hit(addr, A_CFG2)) cfg2_q <= wdata[$bits(cfg2_t)-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if      (hit(addr, A_KEY))  rdata[0] = unlocked;
        else if (hit(addr, A_EN))   rdata[NSRC-1:0] = en_q;
        else if (hit(addr, A_FLAG)) rdata[NSRC-1:0] = flag_q;
        else if (hit(addr, A_IE))   rdata[NSRC-1:0] = ie_q;
        else if (hit(addr, A_CFG0)) rdata[2:0] = cfg0_q;
        else if (hit(addr, A_CFG1)) rdata[$bits(cfg1_t)-1:0] = cfg1_q;
        else if (hit(addr, A_CFG2)) rdata[$bits(cfg2_t)-1:0] = cfg2_q;
        else if (hit(addr, A_STAT)) rdata[NSRC-1:0] = stable_v;
    end

    assign irq = |(flag_q & ie_q);
endmodule

// File: rtl/osc_start_chk.sv
module osc_start_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr,
    input logic [2:0] addr,
    input logic       unlocked,
    input logic [2:0] en,
    input logic [2:0] ie,
    input logic [2:0] flag,
    input logic [2:0] stable,
    input logic [2:0] cfg0,
    input logic [9:0] cfg1,
    input logic [4:0] cfg2,
    input logic       irq
);
    // R4: guarded fields cannot move while the guard is locked
    a_r4_locked_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(cfg0) && $stable(cfg1) && $stable(cfg2)));

    // R6: a flag only rises together with its source becoming stable
    a_r6_flag_rise_stable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag & ~$past(flag) & ~stable) == 3'b000));

    // R7: a flag falls only after a write to the flag register
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == 3'd2) |=> ((~flag & $past(flag)) == 3'b000));

    // R8: stable status follows a low enable within one edge
    a_r8_disable_drops_stable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(~en) & stable) == 3'b000));

    // R9: no request without a flag and an enable
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (flag == 3'b000 || ie == 3'b000) |-> !irq);

    // R11: stable status implies the source is enabled
    a_r11_stable_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ((stable & ~en) != 3'b000) |=> ($past(stable & ~en) != 3'b000) && ((stable & ~$past(en)) == 3'b000));
endmodule

bind osc_start_ctrl osc_start_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .addr     (addr[2:0]),
    .unlocked (unlocked),
    .en       (en_q),
    .ie       (ie_q),
    .flag     (flag_q),
    .stable   (stable_v),
    .cfg0     (cfg0_q),
    .cfg1     (cfg1_q),
    .cfg2     (cfg2_q),
    .irq      (irq)
);

// File: tb/osc_start_ctrl_tb.sv
`timescale 1ns/1ps
module osc_start_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr = 1'b0;
    logic [15:0] rdata;
    logic        irq;
    int n_chk = 0;
    int n_bad = 0;

    localparam int BASE = 4;

    osc_start_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr(wr), .rdata(rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 8; a++) begin
            bus_rd(3'(a), v);
            chk("R1 reset readback", v, 16'h0);
        end
        chk("R1 reset irq", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_guard;
        logic [15:0] v;
        bus_wr(3'd4, 16'h0005);
        bus_rd(3'd4, v); chk("R4 locked cfg0 write ignored", v, 16'h0);
        bus_wr(3'd0, 16'h0096);
        bus_rd(3'd0, v); chk("R2 key opens", v, 16'h1);
        bus_wr(3'd4, 16'h0005);
        bus_wr(3'd5, 16'h03FF);
        bus_wr(3'd6, 16'h001F);
        bus_rd(3'd4, v); chk("R10 cfg0 readback", v, 16'h0005);
        bus_rd(3'd5, v); chk("R10 cfg1 readback", v, 16'h03FF);
        bus_rd(3'd6, v); chk("R10 cfg2 readback", v, 16'h001F);
        bus_wr(3'd5, 16'h0155);
        bus_rd(3'd5, v); chk("R10 cfg1 pattern", v, 16'h0155);
        bus_wr(3'd0, 16'h0097);
        bus_rd(3'd0, v); chk("R3 other key closes", v, 16'h0);
        bus_wr(3'd4, 16'h0002);
        bus_wr(3'd5, 16'h0000);
        bus_wr(3'd6, 16'h0000);
        bus_rd(3'd4, v); chk("R4 cfg0 held", v, 16'h0005);
        bus_rd(3'd5, v); chk("R4 cfg1 held", v, 16'h0155);
        bus_rd(3'd6, v); chk("R4 cfg2 held", v, 16'h001F);
        // set wait selects: cfg1 wsel=1 ([9:8]), cfg2 wsel=2 ([4:2])
        bus_wr(3'd0, 16'h0096);
        bus_wr(3'd5, 16'h0100);
        bus_wr(3'd6, 16'h0008);
        bus_wr(3'd0, 16'h0000);
        bus_rd(3'd0, v); chk("R3 zero key closes", v, 16'h0);
    endtask

    // enable one source with guard locked and measure the delay
    task automatic t_delay(input int src, input int sel, input logic [15:0] en_mask);
        logic [15:0] v;
        int n;
        n = 1 << (BASE + 2 * sel);
        bus_wr(3'd1, en_mask);
        bus_rd(3'd1, v); chk("R5 enable write while locked", v, en_mask);
        repeat (n - 1) @(negedge clk);
        bus_rd(3'd7, v); chk("R11 status low during wait", v & (16'h1 << src), 16'h0);
        @(negedge clk);
        bus_rd(3'd2, v); chk("R6 flag low at edge N", v & (16'h1 << src), 16'h0);
        @(negedge clk);
        bus_rd(3'd2, v); chk("R6 flag high after edge N+1", v & (16'h1 << src), 16'h1 << src);
        bus_rd(3'd7, v); chk("R11 status high when stable", v & (16'h1 << src), 16'h1 << src);
    endtask

    task automatic t_w1c;
        logic [15:0] v;
        bus_wr(3'd2, 16'h0000);
        bus_rd(3'd2, v); chk("R7 write 0 keeps flags", v, 16'h0007);
        bus_wr(3'd2, 16'h0002);
        bus_rd(3'd2, v); chk("R7 write 1 clears bit1", v, 16'h0005);
    endtask

    task automatic t_irq;
        logic [15:0] v;
        chk("R9 irq low with no enables", {15'b0, irq}, 16'h0);
        bus_wr(3'd3, 16'h0002);
        bus_rd(3'd3, v); chk("R5 irq enable write while locked", v, 16'h0002);
        chk("R9 irq low: enabled flag clear", {15'b0, irq}, 16'h0);
        bus_wr(3'd3, 16'h0004);
        chk("R9 irq high: flag2 and ie2", {15'b0, irq}, 16'h1);
        bus_wr(3'd2, 16'h0004);
        chk("R9 irq low after clear", {15'b0, irq}, 16'h0);
        bus_wr(3'd3, 16'h0000);
    endtask

    task automatic t_disable;
        logic [15:0] v;
        bus_wr(3'd1, 16'h0006);
        bus_rd(3'd7, v); chk("R8 status not yet dropped", v & 16'h1, 16'h1);
        @(negedge clk);
        bus_rd(3'd7, v); chk("R8 status dropped", v & 16'h1, 16'h0);
        bus_rd(3'd2, v); chk("R8 flag kept", v & 16'h1, 16'h1);
        bus_wr(3'd2, 16'h0001);
        bus_rd(3'd2, v); chk("R7 flag0 cleared", v & 16'h1, 16'h0);
        t_delay(0, 0, 16'h0007);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_guard();
        t_delay(0, 0, 16'h0001);
        t_delay(1, 1, 16'h0003);
        t_delay(2, 2, 16'h0007);
        t_w1c();
        t_irq();
        t_disable();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule